// File: doc/BRIEF.md
# Serial Transmit Engine with Buffer and Completion Flags

This block turns bytes and control events into an asynchronous serial line. A word is written into a one-entry holding register through a valid/ready port. Whenever the line is free, the word moves into a shift register and goes out least significant bit first, framed by a low start bit and one or two high stop bits. Each word carries 8, 9 or 10 data bits. Besides data, the transmitter sends two special characters. An idle character is one full character time of logic 1. It is queued each time the enable input goes from low to high. A break character is one full character time of logic 0, with the stop positions also low. It is queued by a one-cycle request strobe.

Two status outputs report progress, and they update at different times. `empty_flag` follows the holding register. It drops as soon as a word is accepted and rises only when that word is moved into the shifter at the start of its character, so a character already on the line does not affect it. `done_flag` rises only when nothing is buffered, nothing is queued and the shifter is idle. The line then rests at logic 1. An external `bit_tick` pulse, one clock wide, sets the bit period. A character always starts on a tick, and each bit lasts from one tick to the next.

On the write port, `wr_ready` is high exactly while the holding register is empty. A word is taken on a clock edge where both `wr_valid` and `wr_ready` are high. While `wr_ready` is low, the writer must hold `wr_valid` and `wr_data` stable until the transfer completes. The character format inputs must stay constant while a character is being sent.

Top module: `uart_tx_core`

## Requirements
- R1: After reset, `txd` is 1, `empty_flag` is 1, `done_flag` is 1 and `wr_ready` is 1.
- R2: A data character is a start bit of 0, then the data bits LSB first, then stop bits of 1. The data bit count is 8 for `data_sel`=0, 9 for 1, and 10 for 2 or 3. `two_stop`=1 selects two stop bits and 0 selects one. A character starts on a `bit_tick`, and `txd` changes only on clock edges where `bit_tick` is high.
- R3: `wr_ready` is 1 exactly when the holding register is empty. A word is taken when `wr_valid` and `wr_ready` are both 1. Once a word is taken, `wr_ready` stays 0 until that word moves into the shifter.
- R4: `empty_flag` falls in the cycle after a word is taken. It rises only on the tick edge that moves the word into the shifter, and it stays 0 while another character is on the line ahead of that word.
- R5: `done_flag` is 1 only when the holding register is empty, no idle or break character is queued and no character is being shifted. While it is 1, `txd` is 1.
- R6: `done_flag` is 0 in the cycle after a word is taken.
- R7: A low-to-high change of `tx_en` queues an idle character, which is 1 for a full character length. `done_flag` is 0 from the next cycle until that character ends.
- R8: A 1 on `send_brk` queues a break character, which is 0 for a full character length including the stop positions. `done_flag` is 0 from the next cycle until it ends.
- R9: When several characters are waiting, they leave in this order: the idle character first, then the break character, then buffered data.
- R10: While `tx_en` is 0, no new character starts. `txd` stays 1, and a buffered word stays in the holding register.
- R11: When another character is waiting, it starts on the same tick that ends the current character, with no idle bit between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_valid | input | 1 | Write word offered |
| wr_ready | output | 1 | Holding register can take a word |
| wr_data | input | MAX_DATA | Word to send, LSB first |
| tx_en | input | 1 | Transmitter enable; a rising change queues an idle character |
| send_brk | input | 1 | One-cycle request to queue a break character |
| data_sel | input | 2 | Data bit count select (8, 9, 10, 10) |
| two_stop | input | 1 | 1 selects two stop bits |
| bit_tick | input | 1 | One-cycle bit period pulse |
| txd | output | 1 | Serial output line |
| empty_flag | output | 1 | Holding register empty |
| done_flag | output | 1 | Transmitter fully idle |

## Verification
The bench records the line once per bit period. It sends a break and a word together, which shows whether the design keeps the break ahead of the data and holds `empty_flag` low throughout the break. A design that updated the flag on the write, or on any character start, would raise it too early. The bench also writes a second word while the first is still buffered. A design that ignored back-pressure would lose or overwrite a word, and one that inserted an idle bit between the two would break the back-to-back spacing. Finally, the bench buffers a word while the transmitter is disabled and then enables it. A design that dropped the idle character, or sent it after the data, would put the start bit in the wrong bit slot. A design that let the buffered word go out while disabled would show the start bit too early.

// File: rtl/uart_tx_pkg.sv
package uart_tx_pkg;
  typedef enum logic [1:0] {
    KIND_DATA  = 2'd0,
    KIND_IDLE  = 2'd1,
    KIND_BREAK = 2'd2
  } char_kind_e;
endpackage

// File: rtl/utx_holding.sv
module utx_holding #(
  parameter int DW = 10
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic [DW-1:0] in_data,
  input  logic          take,
  output logic          full,
  output logic [DW-1:0] hold_data
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      full      <= 1'b0;
      hold_data <= '0;
    end else if (in_valid && !full) begin
      full      <= 1'b1;
      hold_data <= in_data;
    end else if (take) begin
      full <= 1'b0;
    end
  end

  assign in_ready = !full;
endmodule

// File: rtl/utx_sched.sv
module utx_sched
  import uart_tx_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       tx_en,
  input  logic       send_brk,
  input  logic       data_waiting,
  input  logic       slot_free,
  output logic       load,
  output char_kind_e kind,
  output logic       take,
  output logic       pending
);
  logic en_q, idle_q, brk_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      idle_q <= 1'b0;
      brk_q  <= 1'b0;
    end else begin
      en_q   <= tx_en;
      idle_q <= (idle_q && !(load && kind == KIND_IDLE)) || (tx_en && !en_q);
      brk_q  <= (brk_q && !(load && kind == KIND_BREAK)) || send_brk;
    end
  end

  // Queued special characters go ahead of buffered data: idle, then break.
  always_comb begin
    if (idle_q)     kind = KIND_IDLE;
    else if (brk_q) kind = KIND_BREAK;
    else            kind = KIND_DATA;
  end

  assign load    = slot_free && tx_en && (idle_q || brk_q || data_waiting);
  assign take    = load && (kind == KIND_DATA);
  assign pending = idle_q || brk_q;
endmodule

// File: rtl/utx_shifter.sv
module utx_shifter
  import uart_tx_pkg::*;
#(
  parameter int MIN_DATA = 8,
  parameter int MAX_DATA = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bit_tick,
  input  logic                load,
  input  char_kind_e          kind,
  input  logic [MAX_DATA-1:0] data,
  input  logic [1:0]          data_sel,
  input  logic                two_stop,
  output logic                txd,
  output logic                busy,
  output logic                slot_free
);
  localparam int FW = MAX_DATA + 3;
  localparam int CW = $clog2(FW + 1);

  logic [FW-1:0] shreg, frame;
  logic [CW-1:0] cnt, n_data, frame_len;

  always_comb begin
    n_data = CW'(MIN_DATA) + CW'(data_sel);
    if (n_data > CW'(MAX_DATA)) n_data = CW'(MAX_DATA);
    frame_len = CW'(1) + n_data + (two_stop ? CW'(2) : CW'(1));
    frame = '1;
    case (kind)
      KIND_BREAK: frame = '0;
      KIND_IDLE:  frame = '1;
      default: begin
        frame[0] = 1'b0;
        for (int i = 0; i < MAX_DATA; i++) begin
          if (CW'(i) < n_data) frame[i+1] = data[i];
        end
      end
    endcase
  end

  assign slot_free = bit_tick && (!busy || cnt == CW'(1));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      cnt   <= '0;
      shreg <= '1;
    end else if (slot_free) begin
      if (load) begin
        shreg <= frame;
        cnt   <= frame_len;
        busy  <= 1'b1;
      end else begin
        shreg <= '1;
        cnt   <= '0;
        busy  <= 1'b0;
      end
    end else if (bit_tick && busy) begin
      shreg <= {1'b1, shreg[FW-1:1]};
      cnt   <= cnt - CW'(1);
    end
  end

  assign txd = busy ? shreg[0] : 1'b1;
endmodule

// File: rtl/uart_tx_core.sv
module uart_tx_core
  import uart_tx_pkg::*;
#(
  parameter int MIN_DATA = 8,
  parameter int MAX_DATA = 10
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  output logic                wr_ready,
  input  logic [MAX_DATA-1:0] wr_data,
  input  logic                tx_en,
  input  logic                send_brk,
  input  logic [1:0]          data_sel,
  input  logic                two_stop,
  input  logic                bit_tick,
  output logic                txd,
  output logic                empty_flag,
  output logic                done_flag
);
  logic                buf_full, take, load, slot_free, busy, pending;
  logic [MAX_DATA-1:0] buf_data;
  char_kind_e          kind;

  utx_holding #(.DW(MAX_DATA)) u_hold (
    .clk(clk), .rst_n(rst_n), .in_valid(wr_valid), .in_ready(wr_ready),
    .in_data(wr_data), .take(take), .full(buf_full), .hold_data(buf_data)
  );

  utx_sched u_sched (
    .clk(clk), .rst_n(rst_n), .tx_en(tx_en), .send_brk(send_brk),
    .data_waiting(buf_full), .slot_free(slot_free), .load(load),
    .kind(kind), .take(take), .pending(pending)
  );

  utx_shifter #(.MIN_DATA(MIN_DATA), .MAX_DATA(MAX_DATA)) u_shift (
    .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .load(load), .kind(kind),
    .data(buf_data), .data_sel(data_sel), .two_stop(two_stop),
    .txd(txd), .busy(busy), .slot_free(slot_free)
  );

  assign empty_flag = !buf_full;
  assign done_flag  = !busy && !buf_full && !pending;
endmodule

// File: rtl/uart_tx_core_chk.sv
module uart_tx_core_chk (
  input logic clk,
  input logic rst_n,
  input logic wr_valid,
  input logic wr_ready,
  input logic tx_en,
  input logic send_brk,
  input logic bit_tick,
  input logic txd,
  input logic empty_flag,
  input logic done_flag
);
  AST_DONE_LINE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
    done_flag |-> txd); // R5
  AST_ACCEPT_CLEARS_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready |=> !empty_flag); // R4
  AST_EMPTY_RISES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(empty_flag) |-> $past(bit_tick)); // R4
  AST_ACCEPT_BLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready |=> !wr_ready); // R3
  AST_ACCEPT_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    wr_valid && wr_ready |=> !done_flag); // R6
  AST_ENABLE_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_en) |=> !done_flag); // R7
  AST_BREAK_CLEARS_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    send_brk |=> !done_flag); // R8
  AST_LINE_MOVES_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(txd) |-> $past(bit_tick)); // R2
endmodule

bind uart_tx_core uart_tx_core_chk u_chk (
  .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
  .tx_en(tx_en), .send_brk(send_brk), .bit_tick(bit_tick), .txd(txd),
  .empty_flag(empty_flag), .done_flag(done_flag)
);

// File: tb/uart_tx_core_bench.sv
`timescale 1ns/1ps
module uart_tx_core_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wr_valid = 1'b0;
  logic       wr_ready;
  logic [9:0] wr_data = '0;
  logic       tx_en = 1'b0;
  logic       send_brk = 1'b0;
  logic [1:0] data_sel = 2'd0;
  logic       two_stop = 1'b0;
  logic       bit_tick = 1'b0;
  logic       txd, empty_flag, done_flag;

  int checks = 0;
  int errors = 0;
  logic cap  [0:255];
  logic expv [0:255];
  int ncap = 0;
  int nexp = 0;

  uart_tx_core u_uart_tx_core (
    .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_ready(wr_ready),
    .wr_data(wr_data), .tx_en(tx_en), .send_brk(send_brk), .data_sel(data_sel),
    .two_stop(two_stop), .bit_tick(bit_tick), .txd(txd),
    .empty_flag(empty_flag), .done_flag(done_flag)
  );

  always #5 clk = ~clk;

  // One tick every 4 cycles; high across exactly one rising edge.
  initial begin
    forever begin
      repeat (3) @(negedge clk);
      #2 bit_tick = 1'b1;
      @(negedge clk);
      #2 bit_tick = 1'b0;
    end
  end

  // Each sample is the line value for the bit period that a tick just began.
  always @(negedge clk) begin
    if (rst_n && bit_tick) begin
      if (ncap < 256) cap[ncap] = txd;
      ncap++;
    end
  end

  initial begin
    #2000000;
    checks++;
    errors++;
    $display("FAIL watchdog: run hung, actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic sync_tick();
    do @(negedge clk); while (!bit_tick);
    #1;
    ncap = 0;
  endtask

  task automatic wait_caps(int k);
    while (ncap < k) begin
      @(negedge clk);
      #1;
    end
  endtask

  task automatic exp_clear();
    nexp = 0;
  endtask

  task automatic exp_lvl(logic v, int n);
    for (int i = 0; i < n; i++) begin
      expv[nexp] = v;
      nexp++;
    end
  endtask

  function automatic int frame_len(logic [1:0] ds, logic ts);
    int d;
    d = (ds >= 2) ? 10 : 8 + int'(ds);
    return 1 + d + (ts ? 2 : 1);
  endfunction

  task automatic exp_frame(logic [9:0] d, logic [1:0] ds, logic ts);
    int nd;
    nd = (ds >= 2) ? 10 : 8 + int'(ds);
    exp_lvl(1'b0, 1);
    for (int i = 0; i < nd; i++) exp_lvl(d[i], 1);
    exp_lvl(1'b1, ts ? 2 : 1);
  endtask

  task automatic compare_line(string req);
    int bad;
    bad = -1;
    wait_caps(nexp);
    for (int i = 0; i < nexp; i++) begin
      if (cap[i] !== expv[i] && bad < 0) bad = i;
    end
    chk(req, "line: first wrong bit slot", bad, -1);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    #1 rst_n = 1'b1;
    @(negedge clk);
    #1;
    chk("R1", "txd", int'(txd), 1);
    chk("R1", "empty_flag", int'(empty_flag), 1);
    chk("R1", "done_flag", int'(done_flag), 1);
    chk("R1", "wr_ready", int'(wr_ready), 1);
  endtask

  task automatic t_enable_idle();
    int len;
    len = frame_len(data_sel, two_stop);
    sync_tick();
    tx_en = 1'b1;
    @(negedge clk);
    #1;
    chk("R7", "done after enable", int'(done_flag), 0);
    wait_caps(len);
    chk("R7", "done during idle char", int'(done_flag), 0);
    wait_caps(len + 1);
    chk("R5", "done after idle char", int'(done_flag), 1);
    exp_clear();
    exp_lvl(1'b1, len + 1);
    compare_line("R7");
  endtask

  task automatic t_data(string req, logic [9:0] d, logic [1:0] ds, logic ts);
    int len;
    data_sel = ds;
    two_stop = ts;
    len = frame_len(ds, ts);
    sync_tick();
    wr_valid = 1'b1;
    wr_data  = d;
    @(negedge clk);
    #1 wr_valid = 1'b0;
    chk("R4", "empty after write", int'(empty_flag), 0);
    chk("R6", "done after write", int'(done_flag), 0);
    chk("R3", "ready after write", int'(wr_ready), 0);
    wait_caps(1);
    chk("R4", "empty at char start", int'(empty_flag), 1);
    wait_caps(len);
    chk("R5", "done in last bit", int'(done_flag), 0);
    exp_clear();
    exp_frame(d, ds, ts);
    exp_lvl(1'b1, 2);
    compare_line(req);
    chk("R5", "done after frame", int'(done_flag), 1);
  endtask

  task automatic t_break(logic [1:0] ds, logic ts);
    int len;
    data_sel = ds;
    two_stop = ts;
    len = frame_len(ds, ts);
    sync_tick();
    send_brk = 1'b1;
    @(negedge clk);
    #1 send_brk = 1'b0;
    chk("R8", "done after break request", int'(done_flag), 0);
    wait_caps(len);
    chk("R8", "done during break", int'(done_flag), 0);
    exp_clear();
    exp_lvl(1'b0, len);
    exp_lvl(1'b1, 2);
    compare_line("R8");
    chk("R5", "done after break", int'(done_flag), 1);
  endtask

  task automatic t_break_then_data();
    int len;
    data_sel = 2'd0;
    two_stop = 1'b0;
    len = frame_len(2'd0, 1'b0);
    sync_tick();
    send_brk = 1'b1;
    wr_valid = 1'b1;
    wr_data  = 10'h03C;
    @(negedge clk);
    #1;
    send_brk = 1'b0;
    wr_valid = 1'b0;
    wait_caps(2);
    chk("R4", "empty held during break", int'(empty_flag), 0);
    wait_caps(len);
    chk("R4", "empty before data start", int'(empty_flag), 0);
    wait_caps(len + 1);
    chk("R4", "empty at data start", int'(empty_flag), 1);
    exp_clear();
    exp_lvl(1'b0, len);
    exp_frame(10'h03C, 2'd0, 1'b0);
    exp_lvl(1'b1, 2);
    compare_line("R9");
  endtask

  task automatic t_back_to_back();
    data_sel = 2'd0;
    two_stop = 1'b1;
    sync_tick();
    wr_valid = 1'b1;
    wr_data  = 10'h0F1;
    @(negedge clk);
    #1 wr_data = 10'h08E;
    chk("R3", "ready while word held", int'(wr_ready), 0);
    while (!wr_ready) begin
      @(negedge clk);
      #1;
    end
    @(negedge clk);
    #1 wr_valid = 1'b0;
    chk("R3", "ready after second accept", int'(wr_ready), 0);
    exp_clear();
    exp_frame(10'h0F1, 2'd0, 1'b1);
    exp_frame(10'h08E, 2'd0, 1'b1);
    exp_lvl(1'b1, 2);
    compare_line("R11");
  endtask

  task automatic t_disabled();
    int len;
    data_sel = 2'd1;
    two_stop = 1'b0;
    len = frame_len(2'd1, 1'b0);
    tx_en = 1'b0;
    sync_tick();
    wr_valid = 1'b1;
    wr_data  = 10'h155;
    @(negedge clk);
    #1 wr_valid = 1'b0;
    wait_caps(3);
    chk("R10", "txd while disabled", int'(txd), 1);
    chk("R10", "word still held", int'(empty_flag), 0);
    chk("R10", "done while disabled", int'(done_flag), 0);
    chk("R10", "line idle over 3 ticks", int'(cap[0] & cap[1] & cap[2]), 1);
    sync_tick();
    tx_en = 1'b1;
    exp_clear();
    exp_lvl(1'b1, len);
    exp_frame(10'h155, 2'd1, 1'b0);
    exp_lvl(1'b1, 2);
    compare_line("R9");
    chk("R5", "done after idle and data", int'(done_flag), 1);
  endtask

  initial begin
    t_reset();
    t_enable_idle();
    t_data("R2", 10'h0A5, 2'd0, 1'b0);
    t_data("R2", 10'h1C3, 2'd1, 1'b1);
    t_data("R2", 10'h2B5, 2'd2, 1'b1);
    t_data("R2", 10'h3A6, 2'd3, 1'b0);
    t_break(2'd0, 1'b0);
    t_break(2'd2, 1'b1);
    t_break_then_data();
    t_back_to_back();
    t_disabled();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule